// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block carries interrupt requests in both directions between a host processor and a coprocessor. Toward the coprocessor there are eight request lines held in an 8-bit register whose bits are active-low. A bus write that places a 0 in a bit raises the request on that line. A 1 in the written data leaves that bit as it was. The coprocessor retires a request with a per-line acknowledge input, which returns the bit to 1.

In the other direction the coprocessor drives a single active-low interrupt to the host through one control bit that only the coprocessor can load. The bus can read both registers. Only two initiators may write the request register: the host and one designated secondary initiator. A write from any other initiator, or any bus write to the coprocessor-owned flag, changes nothing and produces a one-cycle error pulse.

Top module: `ipc_irq_mailbox`

## Requirements
- R1: While reset is asserted, and after it is released, all eight `cp_irq_n` bits are 1, `host_irq_n` is 1, `access_err` is 0 and `rd_data` is 0.
- R2: A permitted write (`bus_valid`=1, `bus_write`=1, `bus_addr`=0) drives low, on the next clock edge, every `cp_irq_n` bit whose `bus_wdata` bit is 0.
- R3: A `bus_wdata` bit of 1 in a permitted write leaves that `cp_irq_n` bit unchanged. A pending request stays pending, apart from the effect of that line's acknowledge.
- R4: Only initiator IDs `HOST_ID` (default 0) and `AUX_ID` (default 5) may write address 0. A write to address 0 from any other ID leaves `cp_irq_n` unchanged apart from acknowledges, and sets `access_err` to 1 on the next cycle.
- R5: `cp_ack[i]`=1 sets `cp_irq_n[i]` to 1 on the next edge. A permitted write in the same cycle with a 0 in bit i wins, and the bit goes to 0.
- R6: `host_irq_n` loads `cp_flag_d` on an edge where `cp_flag_we`=1 and holds its value otherwise.
- R7: A bus write to address 1 (the flag register), from any initiator, leaves `host_irq_n` unchanged and sets `access_err` to 1 on the next cycle.
- R8: A read (`bus_valid`=1, `bus_write`=0) sets `rd_data` on the next cycle. Address 0 returns the request register as it was before that edge. Address 1 returns `{7'b0, host_irq_n}`. `rd_data` holds its value when there is no read.
- R9: `access_err` is 1 exactly in the cycle after a denied or illegal write, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = request register, 1 = coprocessor flag register |
| bus_init | input | 3 | Initiator ID of the access |
| bus_wdata | input | 8 | Write data (a 0 bit raises a request) |
| rd_data | output | 8 | Registered read data |
| access_err | output | 1 | One-cycle pulse after a denied or illegal write |
| cp_ack | input | 8 | Per-line acknowledge from the coprocessor |
| cp_irq_n | output | 8 | Active-low request lines to the coprocessor |
| cp_flag_we | input | 1 | Coprocessor load strobe for its interrupt bit |
| cp_flag_d | input | 1 | Value loaded into the host interrupt bit |
| host_irq_n | output | 1 | Active-low interrupt to the host |

## Verification
The bench targets a write of 0 and an acknowledge hitting the same line in the same cycle. A design that gave the acknowledge priority there would silently lose a fresh request. It also writes 1 over pending lines, which exposes a design that stores the written data instead of combining it with the old value. Writes from every non-permitted initiator and writes to the flag address are covered as well. A design that checks permission loosely, or treats the flag as bus-writable, would change an output or miss the error pulse. Reads issued in the same cycle as an update confirm that read data shows the value from before that edge.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam logic ADDR_REQ  = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;

  typedef struct packed {
    logic req_wr;   // permitted write to the request register
    logic bad_wr;   // denied or illegal write
    logic rd;       // read strobe
    logic rd_flag;  // read selects the flag register
  } acc_dec_t;
endpackage

// File: rtl/ipc_access_check.sv
module ipc_access_check
  import ipc_mbox_pkg::*;
#(
  parameter int INIT_W  = 3,
  parameter int HOST_ID = 0,
  parameter int AUX_ID  = 5
) (
  input  logic              valid,
  input  logic              write,
  input  logic              addr,
  input  logic [INIT_W-1:0] init,
  output acc_dec_t          dec
);
  localparam logic [INIT_W-1:0] HOST_CODE = INIT_W'(HOST_ID);
  localparam logic [INIT_W-1:0] AUX_CODE  = INIT_W'(AUX_ID);

  logic allowed;

  always_comb begin
    allowed     = (init == HOST_CODE) || (init == AUX_CODE);
    dec.req_wr  = valid && write && (addr == ADDR_REQ) && allowed;
    dec.bad_wr  = valid && write && ((addr == ADDR_FLAG) || !allowed);
    dec.rd      = valid && !write;
    dec.rd_flag = (addr == ADDR_FLAG);
  end
endmodule

// File: rtl/ipc_req_bank.sv
module ipc_req_bank #(
  parameter int NUM_REQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_REQ-1:0] wdata,
  input  logic [NUM_REQ-1:0] ack,
  output logic [NUM_REQ-1:0] q
);
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
    logic bit_d;
    logic bit_q;

    always_comb begin
      bit_d = bit_q;
      if (ack[i])
        bit_d = 1'b1;
      if (wr_en && !wdata[i])
        bit_d = 1'b0;   // a new request beats a same-cycle acknowledge
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bit_q <= 1'b1;
      else
        bit_q <= bit_d;
    end

    assign q[i] = bit_q;
  end
endmodule

// File: rtl/ipc_flag_reg.sv
module ipc_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic q
);
  logic flag_d;
  logic flag_q;

  always_comb begin
    flag_d = flag_q;
    if (we)
      flag_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b1;
    else
      flag_q <= flag_d;
  end

  assign q = flag_q;
endmodule

// File: rtl/ipc_irq_mailbox.sv
module ipc_irq_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int INIT_W  = 3,
  parameter int HOST_ID = 0,
  parameter int AUX_ID  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_addr,
  input  logic [INIT_W-1:0]  bus_init,
  input  logic [NUM_REQ-1:0] bus_wdata,
  output logic [NUM_REQ-1:0] rd_data,
  output logic               access_err,
  input  logic [NUM_REQ-1:0] cp_ack,
  output logic [NUM_REQ-1:0] cp_irq_n,
  input  logic               cp_flag_we,
  input  logic               cp_flag_d,
  output logic               host_irq_n
);
  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  acc_dec_t dec;

  ipc_access_check #(
    .INIT_W (INIT_W),
    .HOST_ID(HOST_ID),
    .AUX_ID (AUX_ID)
  ) u_check (
    .valid(bus_valid),
    .write(bus_write),
    .addr (bus_addr),
    .init (bus_init),
    .dec  (dec)
  );

  ipc_req_bank #(.NUM_REQ(NUM_REQ)) u_bank (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .wr_en(dec.req_wr),
    .wdata(bus_wdata),
    .ack  (cp_ack),
    .q    (cp_irq_n)
  );

  ipc_flag_reg u_flag (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .we   (cp_flag_we),
    .d    (cp_flag_d),
    .q    (host_irq_n)
  );

  // Read data and error pulse
  logic [NUM_REQ-1:0] rd_d;
  logic [NUM_REQ-1:0] rd_q;
  logic               err_d;
  logic               err_q;

  always_comb begin
    rd_d  = rd_q;
    if (dec.rd)
      rd_d = dec.rd_flag ? {{(NUM_REQ-1){1'b0}}, host_irq_n} : cp_irq_n;
    err_d = dec.bad_wr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      err_q <= err_d;
    end
  end

  assign rd_data    = rd_q;
  assign access_err = err_q;
endmodule

// File: rtl/ipc_irq_mailbox_chk.sv
module ipc_irq_mailbox_chk #(
  parameter int NUM_REQ = 8,
  parameter int INIT_W  = 3,
  parameter int HOST_ID = 0,
  parameter int AUX_ID  = 5
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic               bus_addr,
  input logic [INIT_W-1:0]  bus_init,
  input logic [NUM_REQ-1:0] bus_wdata,
  input logic [NUM_REQ-1:0] rd_data,
  input logic               access_err,
  input logic [NUM_REQ-1:0] cp_ack,
  input logic [NUM_REQ-1:0] cp_irq_n,
  input logic               cp_flag_we,
  input logic               cp_flag_d,
  input logic               host_irq_n
);
  logic ok_id;
  logic wr_req;
  logic wr_deny;
  assign ok_id   = (bus_init == INIT_W'(HOST_ID)) || (bus_init == INIT_W'(AUX_ID));
  assign wr_req  = bus_valid && bus_write && !bus_addr && ok_id;
  assign wr_deny = bus_valid && bus_write && !bus_addr && !ok_id;

  // R2
  p_write_zero_raises_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_req |=> (cp_irq_n & ~$past(bus_wdata)) == '0);

  // R3
  p_write_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_req |=> ((cp_irq_n ^ ($past(cp_irq_n) | $past(cp_ack))) & $past(bus_wdata)) == '0);

  // R4
  p_denied_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_deny |=> cp_irq_n == ($past(cp_irq_n) | $past(cp_ack)));

  p_denied_err_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_deny |=> access_err);

  // R5
  p_ack_sets_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_req |=> cp_irq_n == ($past(cp_irq_n) | $past(cp_ack)));

  // R6
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cp_flag_we |=> $stable(host_irq_n));

  p_flag_load_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cp_flag_we |=> host_irq_n == $past(cp_flag_d));

  // R7
  p_flag_write_err_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && bus_write && bus_addr) |=> access_err);

  // R8
  p_read_req_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && !bus_write && !bus_addr) |=> rd_data == $past(cp_irq_n));

  p_read_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_valid |=> $stable(rd_data));

  // R9
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_valid && bus_write) |=> !access_err);
endmodule

bind ipc_irq_mailbox ipc_irq_mailbox_chk #(
  .NUM_REQ(NUM_REQ),
  .INIT_W (INIT_W),
  .HOST_ID(HOST_ID),
  .AUX_ID (AUX_ID)
) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_init  (bus_init),
  .bus_wdata (bus_wdata),
  .rd_data   (rd_data),
  .access_err(access_err),
  .cp_ack    (cp_ack),
  .cp_irq_n  (cp_irq_n),
  .cp_flag_we(cp_flag_we),
  .cp_flag_d (cp_flag_d),
  .host_irq_n(host_irq_n)
);

// File: tb/tb_ipc_irq_mailbox.sv
module tb_ipc_irq_mailbox;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       bus_valid;
  logic       bus_write;
  logic       bus_addr;
  logic [2:0] bus_init;
  logic [7:0] bus_wdata;
  logic [7:0] rd_data;
  logic       access_err;
  logic [7:0] cp_ack;
  logic [7:0] cp_irq_n;
  logic       cp_flag_we;
  logic       cp_flag_d;
  logic       host_irq_n;

  ipc_irq_mailbox dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_init(bus_init), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .access_err(access_err), .cp_ack(cp_ack), .cp_irq_n(cp_irq_n),
    .cp_flag_we(cp_flag_we), .cp_flag_d(cp_flag_d), .host_irq_n(host_irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;

  // expected state
  logic [7:0] m_req;
  logic       m_flag;
  logic [7:0] m_rd;
  logic       m_err;

  function automatic logic id_ok(input logic [2:0] id);
    return (id == 3'd0) || (id == 3'd5);
  endfunction

  function automatic logic [7:0] next_req(input logic [7:0] cur, input logic [7:0] ack,
                                          input logic wr, input logic [7:0] d);
    logic [7:0] r;
    r = cur | ack;
    if (wr) r = r & d;
    return r;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic a, input logic [2:0] id,
                     input logic [7:0] d, input logic [7:0] ack,
                     input logic fwe, input logic fd, input string tag);
    logic wr;
    logic bad;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_init = id; bus_wdata = d;
    cp_ack = ack; cp_flag_we = fwe; cp_flag_d = fd;
    wr  = v && w && !a && id_ok(id);
    bad = v && w && (a || !id_ok(id));
    @(posedge clk);
    #1;
    if (v && !w) m_rd = a ? {7'b0, m_flag} : m_req;
    m_req = next_req(m_req, ack, wr, d);
    if (fwe) m_flag = fd;
    m_err = bad;
    check8({tag, " irq"}, cp_irq_n, m_req);
    check8("R6 host_irq_n", {7'b0, host_irq_n}, {7'b0, m_flag});
    check8(bad ? (a ? "R7 err" : "R4 err") : "R9 err", {7'b0, access_err}, {7'b0, m_err});
    check8("R8 rd_data", rd_data, m_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1F3A;
    void'($urandom(seed));
    rst_n = 1'b0;
    bus_valid = 0; bus_write = 0; bus_addr = 0; bus_init = 0; bus_wdata = 0;
    cp_ack = 0; cp_flag_we = 0; cp_flag_d = 0;
    repeat (3) @(posedge clk);
    #1;
    check8("R1 reset cp_irq_n", cp_irq_n, 8'hFF);
    check8("R1 reset host_irq_n", {7'b0, host_irq_n}, 8'h01);
    check8("R1 reset access_err", {7'b0, access_err}, 8'h00);
    check8("R1 reset rd_data", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    m_req = 8'hFF; m_flag = 1'b1; m_rd = 8'h00; m_err = 1'b0;
    check8("R1 after release", cp_irq_n, 8'hFF);

    // directed corner cases
    cyc(1, 1, 0, 3'd0, 8'hFE, 8'h00, 0, 0, "R2 host raise line0");
    cyc(1, 1, 0, 3'd5, 8'h7F, 8'h00, 0, 0, "R2 aux raise line7");
    cyc(1, 1, 0, 3'd0, 8'hFF, 8'h00, 0, 0, "R3 write ones keep pending");
    cyc(1, 0, 0, 3'd2, 8'h00, 8'h00, 0, 0, "R8 read req");
    for (int id = 0; id < 8; id++)
      cyc(1, 1, 0, 3'(id), 8'h00, 8'h00, 0, 0, id_ok(3'(id)) ? "R2 all lines" : "R4 denied");
    cyc(1, 1, 0, 3'd0, 8'hFE, 8'h01, 0, 0, "R5 write beats ack");
    cyc(0, 0, 0, 3'd0, 8'h00, 8'h0F, 0, 0, "R5 ack clears");
    cyc(1, 1, 0, 3'd3, 8'hFF, 8'hF0, 0, 0, "R4 denied with ack");
    cyc(1, 1, 1, 3'd0, 8'h00, 8'h00, 0, 0, "R7 write flag addr");
    cyc(0, 0, 0, 3'd0, 8'h00, 8'h00, 1, 0, "R6 flag load");
    cyc(1, 1, 1, 3'd5, 8'hFF, 8'h00, 0, 0, "R7 aux write flag");
    cyc(1, 0, 1, 3'd1, 8'h00, 8'h00, 1, 1, "R8 read flag same cycle load");
    cyc(0, 0, 0, 3'd0, 8'h00, 8'h00, 0, 0, "R8 rd hold");

    // constrained random
    for (int k = 0; k < 600; k++) begin
      logic v, w, a, fwe, fd;
      logic [2:0] id;
      logic [7:0] d, ack;
      v   = ($urandom % 4) != 0;
      w   = $urandom % 2;
      a   = ($urandom % 5) == 0;
      id  = ($urandom % 2) ? (($urandom % 2) ? 3'd0 : 3'd5) : 3'($urandom);
      d   = 8'($urandom) | 8'($urandom);
      ack = 8'($urandom) & 8'($urandom) & 8'($urandom);
      fwe = ($urandom % 6) == 0;
      fd  = $urandom % 2;
      cyc(v, w, a, id, d, ack, fwe, fd,
          (v && w && !a) ? (id_ok(id) ? "R2/R3 random write" : "R4 random deny") : "R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule